// File: doc/BRIEF.md
# HDLC Link Interrupt Status Register

This block gathers the event and level signals of a framed serial data-link controller into one eight-bit status register that software reads. The controller has a transmitter, a receiver with a serial bit stream, a transmit FIFO, a receive FIFO and a bit-code detector. Most status bits are sticky: an event sets them, and a read strobe clears them. The value on the read port is the register as it stood before that clearing. A per-bit enable mask gates the status bits onto one registered interrupt line.

Two bits report FIFO levels. A mode input switches both of them between sticky capture and a live copy of the level, and in the live form a read does not clear them. A transparent-mode input suppresses the events that only make sense when framing is on. In that mode the transmit-done bit takes its trigger from the transmit FIFO running completely empty. Two side outputs follow the status. One stops new transmission while an underrun abort is unacknowledged. The other asks for a controller reset after a receive overrun, until software applies a reset.

Top module: `hdlc_isr`

## Requirements
- R1: Status bit positions: 0 transmit done, 1 transmit FIFO at/below empty level, 2 transmit underrun abort, 3 receive FIFO at/above full level, 4 receive end of frame, 5 receive overrun, 6 receiver idle, 7 bit code seen. A sticky bit reads 1 on `rd_data` in the cycle after its event input is high at a clock edge.
- R2: A clock edge with `rd_stb` high clears every sticky bit. During that read cycle `rd_data` still shows the value before clearing.
- R3: A sticky bit whose event is high at the same edge as a read stays 1 afterwards.
- R4: With `level_live` = 1, bit 1 equals `tx_at_low` delayed by one clock and is not cleared by a read.
- R5: With `level_live` = 1, bit 3 equals `rx_at_high` delayed by one clock and is not cleared by a read.
- R6: With `transparent` = 0, bit 0 is set by `tx_close_done` and `tx_fifo_drained` has no effect on it. With `transparent` = 1, bit 0 is set by `tx_fifo_drained` and `tx_close_done` has no effect on it.
- R7: With `transparent` = 1, `tx_underrun`, `rx_frame_end` and the idle detection do not set bits 2, 4 and 6.
- R8: Bit 6 is set when the receiver has taken 15 or more consecutive qualified 1 bits (`rx_bit_vld` = 1). A qualified 0 bit restarts the run.
- R9: `irq` is high exactly one clock after a cycle in which some status bit is 1 with its enable set. Bits 0..6 use `ie_mask[0..6]` and bit 7 uses `code_ie`.
- R10: `tx_allow` is 0 whenever status bit 2 is 1. It returns to 1 once a read has cleared that bit.
- R11: `reset_req` goes to 1 the clock after `rx_overrun` and stays 1 until a clock edge with `link_reset` high and no new overrun.
- R12: After reset, `rd_data` = 0, `irq` = 0, `reset_req` = 0 and `tx_allow` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_stb | input | 1 | Read strobe; clears sticky bits at the edge |
| rd_data | output | 8 | Current status register |
| ie_mask | input | 7 | Interrupt enables for status bits 0..6 |
| code_ie | input | 1 | Interrupt enable for status bit 7 |
| level_live | input | 1 | 1: bits 1 and 3 show live FIFO levels |
| transparent | input | 1 | 1: unframed (transparent) operation |
| tx_close_done | input | 1 | Closing flag or abort sequence finished |
| tx_fifo_drained | input | 1 | Transmit FIFO completely empty |
| tx_at_low | input | 1 | Transmit FIFO at or below empty level |
| tx_underrun | input | 1 | Abort sent because of transmit underrun |
| rx_at_high | input | 1 | Receive FIFO at or above full level |
| rx_frame_end | input | 1 | Closing flag or abort received |
| rx_overrun | input | 1 | Receive FIFO overrun |
| rx_bit | input | 1 | Received serial bit |
| rx_bit_vld | input | 1 | Qualifies `rx_bit` |
| code_hit | input | 1 | Bit-code detector match |
| link_reset | input | 1 | Software reset of the controller |
| irq | output | 1 | Registered interrupt |
| tx_allow | output | 1 | Transmission permitted |
| reset_req | output | 1 | Controller reset requested |

## Verification
An event or level seen at edge k shows on `rd_data`, on `tx_allow` and on `reset_req` after edge k. `irq` follows one edge later, because it is registered from the status register. A read at edge k returns the old value during cycle k and shows the cleared value after edge k. The bench drives every input just after a falling edge. It advances its behavioural model at the rising edge from those same input values and compares all outputs at the next falling edge. Each due value is therefore checked in the single cycle where it first becomes valid. Directed sequences cover the read/event collision, the 14- and 15-one idle runs and both transparent-mode triggers. A long random phase follows them.

// File: rtl/hdlc_isr_pkg.sv
package hdlc_isr_pkg;
    localparam int unsigned NSTAT = 8;

    localparam int unsigned B_TXDONE = 0;
    localparam int unsigned B_TXLOW  = 1;
    localparam int unsigned B_UNDR   = 2;
    localparam int unsigned B_RXHIGH = 3;
    localparam int unsigned B_EOF    = 4;
    localparam int unsigned B_OVR    = 5;
    localparam int unsigned B_IDLE   = 6;
    localparam int unsigned B_CODE   = 7;

    typedef logic [NSTAT-1:0] stat_vec_t;

    typedef struct packed {
        logic flag;
    } cell_st_t;

    typedef struct packed {
        logic irq;
        logic req;
    } side_st_t;
endpackage

// File: rtl/hdlc_isr_cell.sv
module hdlc_isr_cell #(
    parameter bit LIVE_OK = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ev,
    input  logic live,
    input  logic lvl,
    input  logic rd,
    output logic q
);
    import hdlc_isr_pkg::*;

    localparam logic LIVE_L = LIVE_OK;

    cell_st_t st_d, st_q;
    logic     live_act;

    assign live_act = live & LIVE_L;

    always_comb begin
        st_d = st_q;
        if (live_act) begin
            st_d.flag = lvl;
        end else begin
            st_d.flag = ev | (st_q.flag & ~rd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.flag;

    // R3: an event wins over a read in the same cycle
    p_event_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!live_act && ev) |=> q);

    // R2: a read with no new event leaves a sticky bit clear
    p_read_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!live_act && rd && !ev) |=> !q);

    // R4 / R5: live bits track the level one clock later, reads ignored
    p_live_tracks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        live_act |=> (q == $past(lvl)));
endmodule

// File: rtl/hdlc_isr_idle.sv
module hdlc_isr_idle #(
    parameter int unsigned IDLE_RUN = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_vld,
    output logic idle_ev
);
    localparam int unsigned CW = $clog2(IDLE_RUN + 1);
    localparam logic [CW-1:0] RUN_MAX  = CW'(IDLE_RUN);
    localparam logic [CW-1:0] RUN_LAST = CW'(IDLE_RUN - 1);

    typedef struct packed {
        logic [CW-1:0] run;
    } idle_st_t;

    idle_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bit_vld) begin
            if (!bit_in) begin
                st_d.run = '0;
            end else if (st_q.run != RUN_MAX) begin
                st_d.run = st_q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idle_ev = bit_vld & bit_in & (st_q.run >= RUN_LAST);

    // R8: a qualified zero restarts the run
    p_zero_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !bit_in) |=> (st_q.run == '0));

    // R8: the run counter never passes its ceiling
    p_run_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run <= RUN_MAX);
endmodule

// File: rtl/hdlc_isr_side.sv
module hdlc_isr_side
    import hdlc_isr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  stat_vec_t        stat,
    input  logic [NSTAT-2:0] ie_mask,
    input  logic             code_ie,
    input  logic             ovr_ev,
    input  logic             link_reset,
    output logic             irq,
    output logic             reset_req
);
    side_st_t  st_d, st_q;
    stat_vec_t en_full;

    assign en_full = {code_ie, ie_mask};

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(stat & en_full);
        st_d.req = ovr_ev | (st_q.req & ~link_reset);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq       = st_q.irq;
    assign reset_req = st_q.req;

    // R9: an enabled set bit raises the interrupt one clock later
    p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat & en_full)) |=> irq);

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat & en_full)) |=> !irq);

    // R11: the request holds until software reset
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && !link_reset) |=> reset_req);

    p_req_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_ev |=> reset_req);
endmodule

// File: rtl/hdlc_isr.sv
module hdlc_isr
    import hdlc_isr_pkg::*;
#(
    parameter int unsigned IDLE_RUN = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_stb,
    output logic [7:0] rd_data,
    input  logic [6:0] ie_mask,
    input  logic       code_ie,
    input  logic       level_live,
    input  logic       transparent,
    input  logic       tx_close_done,
    input  logic       tx_fifo_drained,
    input  logic       tx_at_low,
    input  logic       tx_underrun,
    input  logic       rx_at_high,
    input  logic       rx_frame_end,
    input  logic       rx_overrun,
    input  logic       rx_bit,
    input  logic       rx_bit_vld,
    input  logic       code_hit,
    input  logic       link_reset,
    output logic       irq,
    output logic       tx_allow,
    output logic       reset_req
);
    stat_vec_t ev_vec;
    stat_vec_t lvl_vec;
    stat_vec_t stat_q;
    logic      idle_ev;

    hdlc_isr_idle #(.IDLE_RUN(IDLE_RUN)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (rx_bit),
        .bit_vld (rx_bit_vld),
        .idle_ev (idle_ev)
    );

    always_comb begin
        ev_vec           = '0;
        ev_vec[B_TXDONE] = transparent ? tx_fifo_drained : tx_close_done;
        ev_vec[B_TXLOW]  = tx_at_low;
        ev_vec[B_UNDR]   = tx_underrun & ~transparent;
        ev_vec[B_RXHIGH] = rx_at_high;
        ev_vec[B_EOF]    = rx_frame_end & ~transparent;
        ev_vec[B_OVR]    = rx_overrun;
        ev_vec[B_IDLE]   = idle_ev & ~transparent;
        ev_vec[B_CODE]   = code_hit;

        lvl_vec           = '0;
        lvl_vec[B_TXLOW]  = tx_at_low;
        lvl_vec[B_RXHIGH] = rx_at_high;
    end

    for (genvar gi = 0; gi < NSTAT; gi++) begin : g_cell
        localparam bit IS_LEVEL = (gi == B_TXLOW) || (gi == B_RXHIGH);
        hdlc_isr_cell #(.LIVE_OK(IS_LEVEL)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .ev    (ev_vec[gi]),
            .live  (level_live),
            .lvl   (lvl_vec[gi]),
            .rd    (rd_stb),
            .q     (stat_q[gi])
        );
    end

    hdlc_isr_side u_side (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat       (stat_q),
        .ie_mask    (ie_mask),
        .code_ie    (code_ie),
        .ovr_ev     (ev_vec[B_OVR]),
        .link_reset (link_reset),
        .irq        (irq),
        .reset_req  (reset_req)
    );

    assign rd_data  = stat_q;
    assign tx_allow = ~stat_q[B_UNDR];

    // R7: with transparent operation a clear frame bit stays clear
    p_mask_eof_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (transparent && !stat_q[B_EOF]) |=> !stat_q[B_EOF]);

    p_mask_undr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (transparent && !stat_q[B_UNDR]) |=> !stat_q[B_UNDR]);

    // R10: transmission resumes only after the abort bit is read away
    p_allow_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_allow) |-> $past(rd_stb));
endmodule

// File: tb/sim_hdlc_isr.sv
module sim_hdlc_isr;
    localparam time TCLK = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic [6:0] ie_mask = '0;
    logic       code_ie = 1'b0;
    logic       level_live = 1'b0;
    logic       transparent = 1'b0;
    logic       tx_close_done = 1'b0;
    logic       tx_fifo_drained = 1'b0;
    logic       tx_at_low = 1'b0;
    logic       tx_underrun = 1'b0;
    logic       rx_at_high = 1'b0;
    logic       rx_frame_end = 1'b0;
    logic       rx_overrun = 1'b0;
    logic       rx_bit = 1'b0;
    logic       rx_bit_vld = 1'b0;
    logic       code_hit = 1'b0;
    logic       link_reset = 1'b0;
    logic       irq, tx_allow, reset_req;

    always #(TCLK/2) clk = ~clk;

    hdlc_isr u0 (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit [7:0] m_st;
    int       m_run;
    bit       m_irq, m_req;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string bit_tag(input int b);
        case (b)
            0: return "R6";
            1: return "R4";
            2: return "R7";
            3: return "R5";
            4: return "R7";
            6: return "R8";
            default: return "R1";
        endcase
    endfunction

    task automatic model_edge();
        bit [7:0] ev;
        bit       idle_now;
        int       en;
        idle_now = 1'b0;
        if (rx_bit_vld) begin
            if (rx_bit) begin
                if (m_run + 1 >= 15) idle_now = 1'b1;
                if (m_run < 15) m_run++;
            end else begin
                m_run = 0;
            end
        end
        ev[0] = transparent ? tx_fifo_drained : tx_close_done;
        ev[1] = tx_at_low;
        ev[2] = tx_underrun && !transparent;
        ev[3] = rx_at_high;
        ev[4] = rx_frame_end && !transparent;
        ev[5] = rx_overrun;
        ev[6] = idle_now && !transparent;
        ev[7] = code_hit;
        en = {code_ie, ie_mask};
        m_irq = (int'(m_st) & en) != 0;
        m_req = rx_overrun || (m_req && !link_reset);
        for (int b = 0; b < 8; b++) begin
            if (level_live && (b == 1 || b == 3))
                m_st[b] = (b == 1) ? tx_at_low : rx_at_high;
            else
                m_st[b] = ev[b] || (m_st[b] && !rd_stb);
        end
    endtask

    task automatic compare_all();
        for (int b = 0; b < 8; b++) chk(bit_tag(b), rd_data[b], m_st[b]);
        chk("R9 irq", irq, m_irq);
        chk("R10 tx_allow", tx_allow, !m_st[2]);
        chk("R11 reset_req", reset_req, m_req);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic quiet();
        rd_stb = 0; tx_close_done = 0; tx_fifo_drained = 0; tx_underrun = 0;
        rx_frame_end = 0; rx_overrun = 0; code_hit = 0; link_reset = 0;
        rx_bit_vld = 0;
    endtask

    task automatic do_read();
        rd_stb = 1; step(); rd_stb = 0;
    endtask

    initial begin
        m_st = '0; m_run = 0; m_irq = 0; m_req = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R12 rd_data", rd_data, 0);
        chk("R12 irq", irq, 0);
        chk("R12 tx_allow", tx_allow, 1);
        chk("R12 reset_req", reset_req, 0);

        // R1 / R2: end of frame then read returning old value
        ie_mask = 7'h7f; code_ie = 1;
        rx_frame_end = 1; step(); quiet();
        chk("R1 eof set", rd_data[4], 1);
        step();
        chk("R9 irq after status", irq, 1);
        rd_stb = 1; #1;
        chk("R2 read shows old", rd_data[4], 1);
        step(); rd_stb = 0;
        chk("R2 cleared", rd_data[4], 0);

        // R3: event coincides with read
        code_hit = 1; rd_stb = 1; step(); quiet();
        chk("R3 bit kept", rd_data[7], 1);
        do_read();
        chk("R3 then cleared", rd_data[7], 0);

        // R6: trigger sources per mode
        tx_fifo_drained = 1; step(); quiet();
        chk("R6 drained ignored framed", rd_data[0], 0);
        transparent = 1; tx_close_done = 1; step(); quiet();
        chk("R6 close ignored transparent", rd_data[0], 0);
        tx_fifo_drained = 1; step(); quiet();
        chk("R6 drained transparent", rd_data[0], 1);

        // R7: masked events in transparent mode
        tx_underrun = 1; rx_frame_end = 1; step(); quiet();
        chk("R7 underrun masked", rd_data[2], 0);
        chk("R7 eof masked", rd_data[4], 0);
        transparent = 0; do_read();

        // R10: underrun blocks transmit until read
        tx_underrun = 1; step(); quiet();
        chk("R10 blocked", tx_allow, 0);
        step();
        chk("R10 still blocked", tx_allow, 0);
        do_read();
        chk("R10 allowed", tx_allow, 1);

        // R8: 14 ones, a zero, then 15 ones
        rx_bit_vld = 1; rx_bit = 1;
        repeat (14) step();
        chk("R8 14 ones", rd_data[6], 0);
        rx_bit = 0; step(); rx_bit = 1;
        repeat (14) step();
        chk("R8 restarted", rd_data[6], 0);
        step();
        chk("R8 15 ones", rd_data[6], 1);
        quiet(); do_read();

        // R4 / R5: live levels ignore reads
        level_live = 1; tx_at_low = 1; rx_at_high = 1; step();
        rd_stb = 1; step(); rd_stb = 0;
        chk("R4 live low kept", rd_data[1], 1);
        chk("R5 live high kept", rd_data[3], 1);
        tx_at_low = 0; rx_at_high = 0; step();
        chk("R4 live low gone", rd_data[1], 0);
        chk("R5 live high gone", rd_data[3], 0);
        level_live = 0;

        // R11: overrun request until software reset
        rx_overrun = 1; step(); quiet();
        step();
        chk("R11 req held", reset_req, 1);
        link_reset = 1; step(); quiet();
        chk("R11 req cleared", reset_req, 0);

        // R9: masked interrupt
        ie_mask = 0; code_ie = 0; code_hit = 1; step(); quiet(); step();
        chk("R9 masked irq", irq, 0);
        do_read();

        // random phase
        for (int i = 0; i < 6000; i++) begin
            if (i % 300 == 0) begin
                ie_mask = 7'($urandom); code_ie = 1'($urandom);
            end
            if ($urandom_range(0, 63) == 0) transparent = ~transparent;
            if ($urandom_range(0, 63) == 0) level_live = ~level_live;
            if ($urandom_range(0, 15) == 0) tx_at_low = ~tx_at_low;
            if ($urandom_range(0, 15) == 0) rx_at_high = ~rx_at_high;
            rd_stb          = ($urandom_range(0, 3) == 0);
            tx_close_done   = ($urandom_range(0, 7) == 0);
            tx_fifo_drained = ($urandom_range(0, 7) == 0);
            tx_underrun     = ($urandom_range(0, 15) == 0);
            rx_frame_end    = ($urandom_range(0, 7) == 0);
            rx_overrun      = ($urandom_range(0, 31) == 0);
            code_hit        = ($urandom_range(0, 15) == 0);
            link_reset      = ($urandom_range(0, 15) == 0);
            rx_bit_vld      = ($urandom_range(0, 1) == 0);
            rx_bit          = ($urandom_range(0, 31) != 0);
            step();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule